// File: doc/BRIEF.md
# Static Memory Clock-Domain Power-State Controller

This block decides whether the clock domain of a static memory controller is running or parked. It keeps one of three operating states: Reset, Ready and Low-power. Two sources can ask for Low-power. The first is a software flag, which a set strobe raises and a clear strobe drops. The second is a system clock controller, which takes part in a three-wire handshake: a clock-request input, an acknowledge output and an activity output.

A request is never refused. The block waits until every data FIFO reports empty and every memory interface reports idle, then enters Low-power. While it is parked, no new memory transfer is accepted. It leaves Low-power only when no source is still asking for it. The block never starts an exit by itself. The clock gating and the register bus sit outside this block.

The domain reset is asserted asynchronously and released through a two-stage synchronizer. The state is visible as a 2-bit code: 0 means Ready, 1 means Low-power, 2 means Reset.

Top module: `mc_pwr_ctrl`

## Requirements
- R1: While `rst_n` is LOW, `state_code` is 2, `clk_ack` and `clk_active` are HIGH and `xfer_accept` is LOW.
- R2: After `rst_n` rises, `state_code` stays 2 through two rising edges and becomes 0 (Ready) on the third, with `xfer_accept` HIGH.
- R3: A one-cycle `lp_set` pulse raises the software flag on that edge; on the next edge with all idle inputs HIGH, the state becomes 1 (Low-power), `clk_active` goes LOW and `xfer_accept` goes LOW.
- R4: While any bit of `fifo_empty` or `mif_idle` is LOW, a pending Low-power request holds the state in Ready with `xfer_accept` HIGH.
- R5: When `clk_req` is LOW and all idle inputs are HIGH, Low-power is entered, and `clk_ack` and `clk_active` both fall on that same edge.
- R6: A request that is waiting for idle is not denied: `clk_ack` and `clk_active` stay HIGH while waiting, and `clk_ack` LOW always comes with `clk_active` LOW.
- R7: Once the software flag has been cleared by `lp_clr` and `clk_req` is HIGH, the next edge returns the state to Ready.
- R8: A rising `clk_req` drives `clk_ack` HIGH on the next edge. If the software flag is clear, the state returns to Ready on that same edge.
- R9: When `lp_set` and `lp_clr` are HIGH in the same cycle, the clear takes effect and the flag ends up LOW.
- R10: While in Low-power with a request still standing, the state stays in Low-power regardless of the idle inputs.
- R11: Asserting `rst_n` while in Low-power returns the state to Reset at once and clears the software flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lp_set | input | 1 | One-cycle strobe that raises the software Low-power flag |
| lp_clr | input | 1 | One-cycle strobe that drops the software Low-power flag |
| clk_req | input | 1 | System clock request; LOW asks for Low-power |
| fifo_empty | input | N_FIFO | One bit per data FIFO; HIGH when that FIFO is empty |
| mif_idle | input | N_MIF | One bit per memory interface; HIGH when it is idle |
| clk_ack | output | 1 | Handshake acknowledge; follows `clk_req` once a request is accepted |
| clk_active | output | 1 | HIGH when the domain needs its clock (not in Low-power) |
| xfer_accept | output | 1 | HIGH when new memory transfers may start (Ready only) |
| state_code | output | 2 | 0 Ready, 1 Low-power, 2 Reset |

## Verification
The bench covers requests that arrive while one FIFO or one interface is still busy. A design that skipped the idle check would park with data in flight, and one that denied the request would drop `clk_ack` while `clk_active` stayed HIGH. It raises and clears the flag in the same cycle, where a design that let set win would park when it should not. It also lets the hardware request go away while the software flag still stands: the acknowledge must rise, but the state must stay parked. A wrong design would wake early. Finally, it resets from Low-power and checks that no stale flag parks the domain again after release.

// File: rtl/mc_pwr_pkg.sv
package mc_pwr_pkg;
  typedef enum logic [1:0] {
    ST_READY  = 2'd0,
    ST_LOWPWR = 2'd1,
    ST_RESET  = 2'd2
  } pwr_state_e;
endpackage

// File: rtl/mc_pwr_rst_sync.sv
module mc_pwr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/mc_pwr_swreq.sv
module mc_pwr_swreq (
  input  logic clk,
  input  logic rst_n,
  input  logic lp_set,
  input  logic lp_clr,
  output logic sw_flag
);
  logic flag_q;
  logic flag_d;
  logic flag_en;

  // clear dominates set
  assign flag_en = lp_set | lp_clr;
  assign flag_d  = ~lp_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign sw_flag = flag_q;
endmodule

// File: rtl/mc_pwr_fsm.sv
module mc_pwr_fsm
  import mc_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lp_want,
  input  logic       all_idle,
  output pwr_state_e state,
  output pwr_state_e state_nxt
);
  pwr_state_e state_q;
  pwr_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RESET:  state_d = ST_READY;
      ST_READY:  if (lp_want && all_idle) state_d = ST_LOWPWR;
      ST_LOWPWR: if (!lp_want)            state_d = ST_READY;
      default:   state_d = ST_RESET;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RESET;
    else        state_q <= state_d;
  end

  assign state     = state_q;
  assign state_nxt = state_d;
endmodule

// File: rtl/mc_pwr_hshk.sv
module mc_pwr_hshk
  import mc_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clk_req,
  input  pwr_state_e state,
  input  pwr_state_e state_nxt,
  output logic       clk_ack,
  output logic       clk_active
);
  logic ack_q;
  logic ack_d;
  logic ack_en;

  // ack rises with the request; falls only on the edge the request is granted
  assign ack_en = clk_req | (state_nxt == ST_LOWPWR);
  assign ack_d  = clk_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ack_q <= 1'b1;
    else if (ack_en) ack_q <= ack_d;
  end

  assign clk_ack    = ack_q;
  assign clk_active = (state != ST_LOWPWR);
endmodule

// File: rtl/mc_pwr_ctrl.sv
module mc_pwr_ctrl
  import mc_pwr_pkg::*;
#(
  parameter int N_FIFO    = 3,
  parameter int N_MIF     = 2,
  parameter int RST_SYNCS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lp_set,
  input  logic              lp_clr,
  input  logic              clk_req,
  input  logic [N_FIFO-1:0] fifo_empty,
  input  logic [N_MIF-1:0]  mif_idle,
  output logic              clk_ack,
  output logic              clk_active,
  output logic              xfer_accept,
  output logic [1:0]        state_code
);
  logic       rst_n_s;
  logic       sw_flag;
  logic       lp_want;
  logic       all_idle;
  pwr_state_e state;
  pwr_state_e state_nxt;

  mc_pwr_rst_sync #(.STAGES(RST_SYNCS)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  mc_pwr_swreq u_sw (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .lp_set  (lp_set),
    .lp_clr  (lp_clr),
    .sw_flag (sw_flag)
  );

  assign lp_want  = sw_flag | ~clk_req;
  assign all_idle = (&fifo_empty) & (&mif_idle);

  mc_pwr_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .lp_want   (lp_want),
    .all_idle  (all_idle),
    .state     (state),
    .state_nxt (state_nxt)
  );

  mc_pwr_hshk u_hs (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .clk_req    (clk_req),
    .state      (state),
    .state_nxt  (state_nxt),
    .clk_ack    (clk_ack),
    .clk_active (clk_active)
  );

  assign xfer_accept = (state == ST_READY);
  assign state_code  = state;
endmodule

// File: rtl/mc_pwr_ctrl_chk.sv
module mc_pwr_ctrl_chk #(
  parameter int N_FIFO = 3,
  parameter int N_MIF  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_req,
  input logic [N_FIFO-1:0] fifo_empty,
  input logic [N_MIF-1:0]  mif_idle,
  input logic              clk_ack,
  input logic              clk_active,
  input logic              xfer_accept,
  input logic [1:0]        state_code
);
  always @(negedge clk) begin
    if (!rst_n) begin
      AST_RESET_CODE: assert (state_code == 2'd2 && clk_ack && clk_active && !xfer_accept); // R1
    end
  end

  AST_PARKED_NO_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 2'd1) |-> (!xfer_accept && !clk_active)); // R3

  AST_ENTRY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 2'd1 && $past(state_code) == 2'd0)
      |-> ($past(&fifo_empty) && $past(&mif_idle))); // R4

  AST_ACK_IMPLIES_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_ack |-> (state_code == 2'd1)); // R5

  AST_NO_DENIAL: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_ack |-> !clk_active); // R6

  AST_ACK_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_req) |=> clk_ack); // R8

  AST_HOLD_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 2'd1 && !clk_req) |=> (state_code == 2'd1)); // R10
endmodule

bind mc_pwr_ctrl mc_pwr_ctrl_chk #(.N_FIFO(N_FIFO), .N_MIF(N_MIF)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .clk_req     (clk_req),
  .fifo_empty  (fifo_empty),
  .mif_idle    (mif_idle),
  .clk_ack     (clk_ack),
  .clk_active  (clk_active),
  .xfer_accept (xfer_accept),
  .state_code  (state_code)
);

// File: tb/tb_mc_pwr_ctrl.sv
module tb_mc_pwr_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;
  localparam int NVEC       = 19;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       lp_set, lp_clr, clk_req;
  logic [2:0] fifo_empty;
  logic [1:0] mif_idle;
  logic       clk_ack, clk_active, xfer_accept;
  logic [1:0] state_code;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_pwr_ctrl dut (
    .clk(clk), .rst_n(rst_n), .lp_set(lp_set), .lp_clr(lp_clr),
    .clk_req(clk_req), .fifo_empty(fifo_empty), .mif_idle(mif_idle),
    .clk_ack(clk_ack), .clk_active(clk_active), .xfer_accept(xfer_accept),
    .state_code(state_code)
  );

  typedef struct packed {
    logic       set;
    logic       clr;
    logic       req;
    logic [2:0] fe;
    logic [1:0] mi;
    logic [1:0] code;
    logic       ack;
    logic       act;
    logic       acc;
    logic [3:0] rq;
  } vec_t;

  // inputs applied for one cycle, outputs checked after that edge
  localparam vec_t VECS [NVEC] = '{
    '{1'b0,1'b0,1'b1,3'b111,2'b11, 2'd0,1'b1,1'b1,1'b1, 4'd2},  // R2 idle Ready
    '{1'b1,1'b0,1'b1,3'b111,2'b11, 2'd0,1'b1,1'b1,1'b1, 4'd3},  // R3 flag raised
    '{1'b0,1'b0,1'b1,3'b110,2'b11, 2'd0,1'b1,1'b1,1'b1, 4'd4},  // R4 fifo busy
    '{1'b0,1'b0,1'b1,3'b111,2'b01, 2'd0,1'b1,1'b1,1'b1, 4'd4},  // R4 mif busy
    '{1'b0,1'b0,1'b1,3'b111,2'b11, 2'd1,1'b1,1'b0,1'b0, 4'd3},  // R3 parked
    '{1'b0,1'b0,1'b1,3'b011,2'b11, 2'd1,1'b1,1'b0,1'b0, 4'd10}, // R10
    '{1'b0,1'b1,1'b1,3'b111,2'b11, 2'd1,1'b1,1'b0,1'b0, 4'd7},  // R7 clear edge
    '{1'b0,1'b0,1'b1,3'b111,2'b11, 2'd0,1'b1,1'b1,1'b1, 4'd7},  // R7 back to Ready
    '{1'b0,1'b0,1'b0,3'b101,2'b11, 2'd0,1'b1,1'b1,1'b1, 4'd6},  // R6 waiting
    '{1'b0,1'b0,1'b0,3'b111,2'b11, 2'd1,1'b0,1'b0,1'b0, 4'd5},  // R5 granted
    '{1'b0,1'b0,1'b0,3'b111,2'b10, 2'd1,1'b0,1'b0,1'b0, 4'd10}, // R10
    '{1'b0,1'b0,1'b1,3'b111,2'b11, 2'd0,1'b1,1'b1,1'b1, 4'd8},  // R8 release
    '{1'b1,1'b1,1'b1,3'b111,2'b11, 2'd0,1'b1,1'b1,1'b1, 4'd9},  // R9 both strobes
    '{1'b0,1'b0,1'b1,3'b111,2'b11, 2'd0,1'b1,1'b1,1'b1, 4'd9},  // R9 flag clear
    '{1'b1,1'b0,1'b1,3'b111,2'b11, 2'd0,1'b1,1'b1,1'b1, 4'd3},  // R3 flag raised
    '{1'b0,1'b0,1'b0,3'b111,2'b11, 2'd1,1'b0,1'b0,1'b0, 4'd5},  // R5 both sources
    '{1'b0,1'b0,1'b1,3'b111,2'b11, 2'd1,1'b1,1'b0,1'b0, 4'd8},  // R8 ack up, flag holds
    '{1'b0,1'b1,1'b1,3'b111,2'b11, 2'd1,1'b1,1'b0,1'b0, 4'd7},  // R7 clear edge
    '{1'b0,1'b0,1'b1,3'b111,2'b11, 2'd0,1'b1,1'b1,1'b1, 4'd7}   // R7 Ready
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input int code, input int ack, input int act, input int acc);
    chk(req, "state_code",  int'(state_code),  code);
    chk(req, "clk_ack",     int'(clk_ack),     ack);
    chk(req, "clk_active",  int'(clk_active),  act);
    chk(req, "xfer_accept", int'(xfer_accept), acc);
  endtask

  task automatic idle_inputs();
    lp_set = 1'b0; lp_clr = 1'b0; clk_req = 1'b1;
    fifo_empty = 3'b111; mif_idle = 2'b11;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    idle_inputs();
    repeat (3) @(negedge clk);
    chk_all("R1", 2, 1, 1, 0);
    rst_n = 1'b1;
    tick();
    chk("R2", "state_code after 1 edge", int'(state_code), 2);
    tick();
    chk("R2", "state_code after 2 edges", int'(state_code), 2);
    tick();
    chk_all("R2", 0, 1, 1, 1);

    for (int i = 0; i < NVEC; i++) begin
      lp_set     = VECS[i].set;
      lp_clr     = VECS[i].clr;
      clk_req    = VECS[i].req;
      fifo_empty = VECS[i].fe;
      mif_idle   = VECS[i].mi;
      tick();
      chk_all($sformatf("R%0d(vec %0d)", VECS[i].rq, i),
              VECS[i].code, VECS[i].ack, VECS[i].act, VECS[i].acc);
    end

    // R11: reset from Low-power, flag must not survive
    idle_inputs();
    lp_set = 1'b1;
    tick();
    lp_set = 1'b0;
    clk_req = 1'b0;
    tick();
    chk_all("R11 parked before reset", 1, 0, 0, 0);
    #1 rst_n = 1'b0;
    #1 chk_all("R11", 2, 1, 1, 0);
    @(negedge clk);
    clk_req = 1'b1;
    rst_n = 1'b1;
    repeat (3) tick();
    chk_all("R11 after release", 0, 1, 1, 1);
    repeat (2) tick();
    chk_all("R11 flag cleared", 0, 1, 1, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule